// File: doc/BRIEF.md
# Timing Loop Operating-Mode Controller

This block is the state machine that decides which operating mode a digital PLL in a network timing source is in. It watches four status lines from the surrounding loop: a reference has been chosen, the chosen reference is valid, the loop reports lock, and the loop reports lost phase. From these it steps through three lasting modes (free-run, locked, holdover) and three passing modes (pre-locked, second pre-locked, phase-lost). The current mode comes out as a 3-bit code.

Both pre-locked modes run a lock-acquisition timer. If lock does not arrive within `LOCK_TIMEOUT` clock cycles, the controller gives up. It falls back to free-run from pre-locked, or to holdover from second pre-locked, and raises a one-cycle request for the reference selector to pick a different source. The timeout is a cycle-count parameter: a real build sets it to about 100 seconds of clock, and a simulation sets it short.

A forced-control input turns the automatic rules off. While forced control is on, the state changes only when software writes a legal state code.

Top module: `tloop_mode_ctrl`

## Requirements
- R1: After `rst_ni` is released, `state_o` is 001 (free-run), `reselect_o` is 0 and control is automatic.
- R2: `state_o` only ever carries one of these codes: free-run 001, holdover 010, locked 100, pre-locked 101, second pre-locked 110, phase-lost 111.
- R3: In automatic control, free-run moves to pre-locked on the clock edge at which `ref_sel_i` is high.
- R4: In automatic control, pre-locked or second pre-locked moves to locked on the edge at which both `ref_sel_i` and `loop_lock_i` are high.
- R5: Pre-locked moves to free-run after it has spent `LOCK_TIMEOUT` cycles in the state without meeting R4. `reselect_o` is 1 in exactly the first free-run cycle.
- R6: Second pre-locked times out the same way, but it moves to holdover. `reselect_o` is 1 in exactly the first holdover cycle.
- R7: Locked moves to phase-lost when `phase_lost_i` is high. Phase-lost returns to locked when `loop_lock_i` is high and `phase_lost_i` is low.
- R8: Locked or phase-lost moves to holdover whenever `ref_valid_i` is low. This takes priority over R7.
- R9: Holdover moves to second pre-locked when both `ref_sel_i` and `ref_valid_i` are high.
- R10: While `force_en_i` is high, no automatic transition or timeout occurs. A `force_wr_i` pulse carrying a legal code from R2 sets `state_o` to that code on the next cycle. `reselect_o` stays 0.
- R11: A write carrying an illegal code (000 or 011), or a write made while `force_en_i` is low, leaves the state unchanged.
- R12: The lock timer counts residency in a pre-locked state, including cycles spent there under forced control. It restarts only when the state changes. After forced control is released, a timer that has already reached its limit fires at the first automatic edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sel_i | input | 1 | A reference source is selected |
| ref_valid_i | input | 1 | The selected reference is qualified |
| loop_lock_i | input | 1 | The loop reports lock |
| phase_lost_i | input | 1 | The loop reports lost phase |
| force_en_i | input | 1 | Forced control on; automatic rules suspended |
| force_wr_i | input | 1 | Write strobe for a forced state |
| force_state_i | input | 3 | State code to force |
| state_o | output | 3 | Current state code |
| reselect_o | output | 1 | One-cycle request to choose another reference |

## Verification
Every transition is registered, so a wrong next-state decision shows up on `state_o` exactly one cycle after the deciding input edge. Because the bench compares the state on every cycle, a wrong state is caught within one cycle. An error in the timer does not show until a pre-locked residency runs out: a timeout that comes early or late moves the fallback edge and the `reselect_o` pulse by the same number of cycles. A timer that fails to restart on entry shows only on the next visit to a pre-locked state, and the bench makes several such visits back to back.

// File: rtl/tloop_pkg.sv
package tloop_pkg;
  typedef enum logic [2:0] {
    ST_FREE  = 3'b001,
    ST_HOLD  = 3'b010,
    ST_LOCK  = 3'b100,
    ST_PRE   = 3'b101,
    ST_PRE2  = 3'b110,
    ST_PHLOS = 3'b111
  } mode_e;

  function automatic logic code_legal(logic [2:0] c);
    return (c != 3'b000) && (c != 3'b011);
  endfunction

  function automatic logic is_pre(logic [2:0] c);
    return (c == ST_PRE) || (c == ST_PRE2);
  endfunction
endpackage

// File: rtl/tloop_lock_timer.sv
module tloop_lock_timer #(
  parameter int unsigned LOCK_TIMEOUT = 32'd100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned LIMIT = (LOCK_TIMEOUT > 1) ? LOCK_TIMEOUT - 1 : 0;
  localparam int unsigned CW    = (LOCK_TIMEOUT > 2) ? $clog2(LOCK_TIMEOUT) : 1;
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i)                cnt_q <= '0;
    else if (run_i && cnt_q != LIM_C)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LIM_C);

  // R12: counter never runs past its limit
  a_r12_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_C);
  // R12: restart always lands on zero
  a_r12_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/tloop_force_dec.sv
module tloop_force_dec (
  input  logic       force_en_i,
  input  logic       force_wr_i,
  input  logic [2:0] force_state_i,
  output logic       take_o,
  output logic       hold_auto_o
);
  import tloop_pkg::*;
  assign hold_auto_o = force_en_i;
  assign take_o      = force_en_i && force_wr_i && code_legal(force_state_i);
endmodule

// File: rtl/tloop_mode_next.sv
module tloop_mode_next (
  input  logic [2:0] state_i,
  input  logic       ref_sel_i,
  input  logic       ref_valid_i,
  input  logic       loop_lock_i,
  input  logic       phase_lost_i,
  input  logic       expired_i,
  input  logic       hold_auto_i,
  input  logic       take_i,
  input  logic [2:0] force_state_i,
  output logic [2:0] state_d_o,
  output logic       reselect_d_o
);
  import tloop_pkg::*;

  logic lock_ok;
  assign lock_ok = ref_sel_i && loop_lock_i;

  always_comb begin
    state_d_o    = state_i;
    reselect_d_o = 1'b0;
    if (hold_auto_i) begin
      if (take_i) state_d_o = force_state_i;
    end else begin
      unique case (state_i)
        ST_FREE:  if (ref_sel_i) state_d_o = ST_PRE;
        ST_PRE: begin
          if (lock_ok) state_d_o = ST_LOCK;
          else if (expired_i) begin
            state_d_o    = ST_FREE;
            reselect_d_o = 1'b1;
          end
        end
        ST_PRE2: begin
          if (lock_ok) state_d_o = ST_LOCK;
          else if (expired_i) begin
            state_d_o    = ST_HOLD;
            reselect_d_o = 1'b1;
          end
        end
        ST_LOCK: begin
          if (!ref_valid_i)      state_d_o = ST_HOLD;
          else if (phase_lost_i) state_d_o = ST_PHLOS;
        end
        ST_PHLOS: begin
          if (!ref_valid_i)                      state_d_o = ST_HOLD;
          else if (loop_lock_i && !phase_lost_i) state_d_o = ST_LOCK;
        end
        ST_HOLD:  if (ref_sel_i && ref_valid_i) state_d_o = ST_PRE2;
        default:  state_d_o = ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/tloop_mode_ctrl.sv
module tloop_mode_ctrl #(
  parameter int unsigned LOCK_TIMEOUT = 32'd100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_sel_i,
  input  logic       ref_valid_i,
  input  logic       loop_lock_i,
  input  logic       phase_lost_i,
  input  logic       force_en_i,
  input  logic       force_wr_i,
  input  logic [2:0] force_state_i,
  output logic [2:0] state_o,
  output logic       reselect_o
);
  import tloop_pkg::*;

  logic [2:0] state_q, state_d;
  logic       resel_q, resel_d;
  logic       expired, take, hold_auto;

  tloop_force_dec u_force (
    .force_en_i   (force_en_i),
    .force_wr_i   (force_wr_i),
    .force_state_i(force_state_i),
    .take_o       (take),
    .hold_auto_o  (hold_auto)
  );

  tloop_lock_timer #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(state_d != state_q),
    .run_i    (is_pre(state_q)),
    .expired_o(expired)
  );

  tloop_mode_next u_next (
    .state_i      (state_q),
    .ref_sel_i    (ref_sel_i),
    .ref_valid_i  (ref_valid_i),
    .loop_lock_i  (loop_lock_i),
    .phase_lost_i (phase_lost_i),
    .expired_i    (expired),
    .hold_auto_i  (hold_auto),
    .take_i       (take),
    .force_state_i(force_state_i),
    .state_d_o    (state_d),
    .reselect_d_o (resel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      resel_q <= 1'b0;
    end else begin
      state_q <= state_d;
      resel_q <= resel_d;
    end
  end

  assign state_o    = state_q;
  assign reselect_o = resel_q;

  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_legal(state_q));
  a_r3_free_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FREE && !force_en_i && ref_sel_i) |=> state_q == ST_PRE);
  a_r4_lock_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre(state_q) && !force_en_i && ref_sel_i && loop_lock_i) |=> state_q == ST_LOCK);
  a_r5_pre_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE && !force_en_i && !(ref_sel_i && loop_lock_i) && expired)
      |=> (state_q == ST_FREE && reselect_o));
  a_r6_pre2_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE2 && !force_en_i && !(ref_sel_i && loop_lock_i) && expired)
      |=> (state_q == ST_HOLD && reselect_o));
  a_r8_ref_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_LOCK || state_q == ST_PHLOS) && !force_en_i && !ref_valid_i)
      |=> state_q == ST_HOLD);
  a_r10_forced_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_en_i && force_wr_i && code_legal(force_state_i))
      |=> (state_q == $past(force_state_i) && !reselect_o));
  a_r11_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_en_i && !(force_wr_i && code_legal(force_state_i))) |=> $stable(state_q));
  a_r5_pulse_place: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reselect_o |-> (state_q == ST_FREE || state_q == ST_HOLD));
endmodule

// File: tb/tloop_mode_ctrl_tb.sv
module tloop_mode_ctrl_tb;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, vld = 0, lck = 0, plost = 0, fen = 0, fwr = 0;
  logic [2:0] fst = 3'b000;
  logic [2:0] st;
  logic rs;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  tloop_mode_ctrl #(.LOCK_TIMEOUT(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_sel_i(sel), .ref_valid_i(vld),
    .loop_lock_i(lck), .phase_lost_i(plost), .force_en_i(fen),
    .force_wr_i(fwr), .force_state_i(fst), .state_o(st), .reselect_o(rs)
  );

  // behavioural reference model
  logic [2:0] m_st;
  logic       m_rs;
  int         m_cnt;

  always @(posedge clk or negedge rst_n) begin
    logic [2:0] n;
    logic r;
    if (!rst_n) begin
      m_st = 3'b001; m_rs = 0; m_cnt = 0;
    end else begin
      n = m_st; r = 0;
      if (fen) begin
        if (fwr && fst != 3'b000 && fst != 3'b011) n = fst;
      end else begin
        case (m_st)
          3'b001: if (sel) n = 3'b101;
          3'b101: if (sel && lck) n = 3'b100;
                  else if (m_cnt >= TO-1) begin n = 3'b001; r = 1; end
          3'b110: if (sel && lck) n = 3'b100;
                  else if (m_cnt >= TO-1) begin n = 3'b010; r = 1; end
          3'b100: if (!vld) n = 3'b010; else if (plost) n = 3'b111;
          3'b111: if (!vld) n = 3'b010; else if (lck && !plost) n = 3'b100;
          3'b010: if (sel && vld) n = 3'b110;
          default: n = 3'b001;
        endcase
      end
      if (n != m_st) m_cnt = 0;
      else if ((m_st == 3'b101 || m_st == 3'b110) && m_cnt < TO-1) m_cnt++;
      m_st = n; m_rs = r;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (st !== m_st || rs !== m_rs) begin
        errors++;
        $display("FAIL %s cyc=%0d actual state=%b resel=%b expected state=%b resel=%b",
                 tag, cyc, st, rs, m_st, m_rs);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(logic [2:0] e, logic er, string r);
    checks++;
    if (st !== e || rs !== er) begin
      errors++;
      $display("FAIL %s actual state=%b resel=%b expected state=%b resel=%b", r, st, rs, e, er);
    end
  endtask

  task automatic fwrite(logic [2:0] c);
    fwr = 1; fst = c; wait_cyc(1); fwr = 0; fst = 3'b000;
  endtask

  initial begin
    wait_cyc(3);
    expect_st(3'b001, 1'b0, "R1");
    rst_n = 1;
    wait_cyc(2);
    expect_st(3'b001, 1'b0, "R1");

    tag = "R3"; vld = 1; sel = 1; wait_cyc(1);
    expect_st(3'b101, 1'b0, "R3");
    tag = "R5"; wait_cyc(TO);
    expect_st(3'b001, 1'b1, "R5");
    wait_cyc(1);
    expect_st(3'b101, 1'b0, "R5");   // retry with fresh timer
    tag = "R4"; wait_cyc(TO-2); lck = 1; wait_cyc(1);
    expect_st(3'b100, 1'b0, "R4");
    tag = "R7"; plost = 1; wait_cyc(1);
    expect_st(3'b111, 1'b0, "R7");
    lck = 0; wait_cyc(2); plost = 0; lck = 1; wait_cyc(1);
    expect_st(3'b100, 1'b0, "R7");
    tag = "R8"; vld = 0; plost = 1; wait_cyc(1);
    expect_st(3'b010, 1'b0, "R8");
    tag = "R9"; lck = 0; plost = 0; wait_cyc(2); vld = 1; wait_cyc(1);
    expect_st(3'b110, 1'b0, "R9");
    tag = "R6"; wait_cyc(TO);
    expect_st(3'b010, 1'b1, "R6");
    wait_cyc(1);
    expect_st(3'b110, 1'b0, "R6");
    tag = "R4"; lck = 1; wait_cyc(1);
    expect_st(3'b100, 1'b0, "R4");
    tag = "R8"; plost = 1; wait_cyc(1); vld = 0; wait_cyc(1);
    expect_st(3'b010, 1'b0, "R8");
    plost = 0; lck = 0; sel = 0; vld = 1; wait_cyc(3);

    tag = "R10"; fen = 1; fwrite(3'b111);
    expect_st(3'b111, 1'b0, "R10");
    vld = 0; wait_cyc(3);
    expect_st(3'b111, 1'b0, "R10");
    tag = "R11"; fwrite(3'b000); expect_st(3'b111, 1'b0, "R11");
    fwrite(3'b011); expect_st(3'b111, 1'b0, "R11");
    tag = "R12"; vld = 1; fwrite(3'b101);
    wait_cyc(TO+4);
    expect_st(3'b101, 1'b0, "R10");
    fen = 0; wait_cyc(1);
    expect_st(3'b001, 1'b1, "R12");
    tag = "R11"; fwr = 1; fst = 3'b100; wait_cyc(1); fwr = 0;
    expect_st(3'b001, 1'b0, "R11");

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      sel   = ($urandom % 4) != 0;
      vld   = ($urandom % 8) != 0;
      lck   = ($urandom % 24) == 0;
      plost = ($urandom % 10) == 0;
      fen   = ($urandom % 50) == 0;
      fwr   = ($urandom % 2) == 0;
      fst   = 3'($urandom);
      wait_cyc(1);
    end
    fen = 0; fwr = 0;
    wait_cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule